// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a signed 64-bit running sum split into an upper and a lower 32-bit half. It accepts one command at a time. A long command multiplies two full 32-bit signed operands and adds the product into the sum. A short command multiplies only the sign-extended low 16 bits of each operand and adds that product. A clear command empties the sum. Both halves are visible on output ports at all times.

A saturation-enable bit travels with each multiply command. The two multiply widths apply different rules. A long multiply forces the upper half to a sign-dependent masked pattern. A short multiply clamps to the signed 32-bit range and marks the clamp by setting the upper half to one. Both rules judge overflow on the exact sum, before any truncation.

Each command takes two clock edges to reach the sum. The block then raises a single-cycle completion pulse. While a command is in flight, `busy` is high and further commands are not taken.

Top module: `mac_sat_unit`

## Requirements
- R1: While `rst_n` is low, both halves of the sum clear to zero and `done` and `busy` drop to 0 at the next clock edge. This holds even if a command is in flight.
- R2: Command code 2'b01 (long), with `sat_en` low, adds the product of `opnd_a` and `opnd_b`, both read as signed 32-bit values, into the 64-bit sum. The result wraps modulo 2^64.
- R3: Command code 2'b10 (short), with `sat_en` low, adds the product of bits [15:0] of each operand, each read as signed 16-bit, into the sum. Bits [31:16] of both operands have no effect, and the full 64-bit wrapped sum is kept.
- R4: A long command with `sat_en` high whose exact sum is negative stores the wrapped lower half unchanged. It stores the wrapped upper half ORed with 0xFFFF0000.
- R5: A long command with `sat_en` high whose exact sum is zero or positive stores the wrapped lower half unchanged. It stores the wrapped upper half ANDed with 0x00007FFF.
- R6: A short command with `sat_en` high whose exact sum is below -2^31 stores upper half 0x00000001 and lower half 0x80000000.
- R7: A short command with `sat_en` high whose exact sum is above 2^31-1 stores upper half 0x00000001 and lower half 0x7FFFFFFF.
- R8: A short command with `sat_en` high whose exact sum lies in [-2^31, 2^31-1] keeps the full sum. The two end points count as in range.
- R9: Command code 2'b11 (clear) sets both halves to zero, whatever the operands and `sat_en`.
- R10: A command is taken at a rising edge where `cmd_valid` is high, `busy` is low and the code is not 2'b00. `busy` is high after that edge. The sum changes at the second edge. `done` is high for exactly the one cycle after the third edge, and `busy` is low again in that cycle.
- R11: A command presented while `busy` is high, or carrying code 2'b00, is ignored. It changes neither the sum nor `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is presented |
| cmd_op | input | 2 | 00 none, 01 long multiply, 10 short multiply, 11 clear |
| sat_en | input | 1 | Apply the saturation rule of the command |
| opnd_a | input | 32 | First multiplicand |
| opnd_b | input | 32 | Second multiplicand |
| busy | output | 1 | A command is in flight; new commands are not taken |
| done | output | 1 | One-cycle pulse after the sum update is committed |
| acc_hi | output | 32 | Upper half of the sum |
| acc_lo | output | 32 | Lower half of the sum |

## Verification
The bench builds the unit with its default parameters: 32-bit halves and a 16-bit short operand. With these values, plain operands such as 0x80000000 and 0x7FFFFFFF land the exact sum on -2^31 and 2^31-1, and on either side of them. Four products of 2^62 carry the sum past 2^64 and back to zero. The masked upper half of the long rule shows up on sums whose upper word is far from all-ones or zero.

// File: rtl/mac_pkg.sv
// Package: shared command encoding for the saturating multiply-accumulate unit.
// Assumes: the 2-bit code on the command port maps one-to-one onto mac_op_e.
package mac_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_LONG  = 2'b01,
        OP_WORD  = 2'b10,
        OP_CLEAR = 2'b11
    } mac_op_e;
endpackage

// File: rtl/mac_mult_stage.sv
// Module: mac_mult_stage
// Takes one command, picks full or short signed operands and registers the
// signed product together with the command code and saturation bit.
// Assumes: take is only raised when the pipeline is empty; SHORT_W < HALF_W.
module mac_mult_stage
    import mac_pkg::*;
#(
    parameter int HALF_W  = 32,
    parameter int SHORT_W = 16,
    localparam int ACC_W  = 2 * HALF_W,
    localparam int PAD_W  = HALF_W - SHORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  mac_op_e           op_in,
    input  logic              sat_in,
    input  logic [HALF_W-1:0] opnd_a,
    input  logic [HALF_W-1:0] opnd_b,
    output logic              s1_vld,
    output mac_op_e           s1_op,
    output logic              s1_sat,
    output logic [ACC_W-1:0]  s1_prod
);
    logic [HALF_W-1:0] raw  [2];
    logic [HALF_W-1:0] ext  [2];
    logic [ACC_W-1:0]  wide [2];
    logic [ACC_W-1:0]  prod_c;
    logic              short_mode;

    assign raw[0]     = opnd_a;
    assign raw[1]     = opnd_b;
    assign short_mode = (op_in == OP_WORD);

    // Per-operand width selection and sign extension to the product width.
    for (genvar i = 0; i < 2; i++) begin : g_opnd
        assign ext[i]  = short_mode
                       ? {{PAD_W{raw[i][SHORT_W-1]}}, raw[i][SHORT_W-1:0]}
                       : raw[i];
        assign wide[i] = {{HALF_W{ext[i][HALF_W-1]}}, ext[i]};
    end

    // Low ACC_W bits of the product of two sign-extended values are exact.
    assign prod_c = wide[0] * wide[1];

    // Stage register: capture the command and its product when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_op   <= OP_IDLE;
            s1_sat  <= 1'b0;
            s1_prod <= '0;
        end else begin
            s1_vld <= take;
            if (take) begin
                s1_op   <= op_in;
                s1_sat  <= sat_in;
                s1_prod <= prod_c;
            end
        end
    end
endmodule

// File: rtl/mac_sat_logic.sv
// Module: mac_sat_logic
// Combinational next-sum: adds the product at full precision, then applies the
// saturation rule of the command (masked upper half for long, clamp for short).
// Assumes: op is never OP_IDLE when the result is used.
module mac_sat_logic
    import mac_pkg::*;
#(
    parameter int HALF_W = 32,
    localparam int ACC_W = 2 * HALF_W,
    localparam int FULL_W = ACC_W + 1
) (
    input  logic [ACC_W-1:0] acc_cur,
    input  logic [ACC_W-1:0] prod,
    input  mac_op_e          op,
    input  logic             sat,
    output logic [ACC_W-1:0] acc_nxt
);
    localparam logic [HALF_W-1:0] NEG_MASK = ~((HALF_W'(1) << (HALF_W / 2)) - HALF_W'(1));
    localparam logic [HALF_W-1:0] POS_MASK = (HALF_W'(1) << (HALF_W / 2 - 1)) - HALF_W'(1);
    localparam logic signed [FULL_W-1:0] W_MAX = (FULL_W'(1) << (HALF_W - 1)) - FULL_W'(1);
    localparam logic signed [FULL_W-1:0] W_MIN = -(FULL_W'(1) << (HALF_W - 1));
    localparam logic [HALF_W-1:0] CLAMP_HI = HALF_W'(1);
    localparam logic [HALF_W-1:0] CLAMP_LO_NEG = {1'b1, {(HALF_W-1){1'b0}}};
    localparam logic [HALF_W-1:0] CLAMP_LO_POS = {1'b0, {(HALF_W-1){1'b1}}};

    logic signed [FULL_W-1:0] full;
    logic [HALF_W-1:0]        wrap_hi;
    logic [HALF_W-1:0]        wrap_lo;
    logic                     below;
    logic                     above;

    // Exact sum, one bit wider than the accumulator.
    assign full    = $signed({acc_cur[ACC_W-1], acc_cur}) + $signed({prod[ACC_W-1], prod});
    assign wrap_hi = full[ACC_W-1:HALF_W];
    assign wrap_lo = full[HALF_W-1:0];
    assign below   = (full < W_MIN);
    assign above   = (full > W_MAX);

    // Rule selection per command code and saturation bit.
    always_comb begin
        acc_nxt = {wrap_hi, wrap_lo};
        unique case (op)
            OP_CLEAR: acc_nxt = '0;
            OP_LONG: begin
                if (sat) begin
                    if (full[FULL_W-1]) acc_nxt = {wrap_hi | NEG_MASK, wrap_lo};
                    else                acc_nxt = {wrap_hi & POS_MASK, wrap_lo};
                end
            end
            OP_WORD: begin
                if (sat && below)      acc_nxt = {CLAMP_HI, CLAMP_LO_NEG};
                else if (sat && above) acc_nxt = {CLAMP_HI, CLAMP_LO_POS};
            end
            default: acc_nxt = acc_cur;
        endcase
    end
endmodule

// File: rtl/mac_acc_reg.sv
// Module: mac_acc_reg
// Holds the accumulator, commits the next sum when the stage ahead is valid,
// and produces the commit flag and the completion pulse one edge later.
// Assumes: load is a single-cycle strobe per command.
module mac_acc_reg #(
    parameter int HALF_W = 32,
    localparam int ACC_W = 2 * HALF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ACC_W-1:0] acc_nxt,
    output logic [ACC_W-1:0] acc_q,
    output logic             commit_q,
    output logic             done_q
);
    // Accumulator storage, zeroed by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= '0;
        else if (load) acc_q <= acc_nxt;
    end

    // Commit flag then completion pulse, each one edge apart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            commit_q <= load;
            done_q   <= commit_q;
        end
    end
endmodule

// File: rtl/mac_sat_unit.sv
// Module: mac_sat_unit (top)
// Saturating multiply-accumulate: one command in flight, product stage, then
// accumulate-and-saturate, then a completion pulse.
// Assumes: the caller waits for busy low; commands offered while busy are dropped.
module mac_sat_unit
    import mac_pkg::*;
#(
    parameter int HALF_W  = 32,
    parameter int SHORT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              sat_en,
    input  logic [HALF_W-1:0] opnd_a,
    input  logic [HALF_W-1:0] opnd_b,
    output logic              busy,
    output logic              done,
    output logic [HALF_W-1:0] acc_hi,
    output logic [HALF_W-1:0] acc_lo
);
    localparam int ACC_W = 2 * HALF_W;

    mac_op_e          op_in;
    logic             take;
    logic             s1_vld;
    mac_op_e          s1_op;
    logic             s1_sat;
    logic [ACC_W-1:0] s1_prod;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_nxt;
    logic             commit_q;

    // Acceptance: valid code, nothing in flight.
    assign op_in = mac_op_e'(cmd_op);
    assign take  = cmd_valid && !busy && (op_in != OP_IDLE);
    assign busy  = s1_vld | commit_q;

    mac_mult_stage #(.HALF_W(HALF_W), .SHORT_W(SHORT_W)) u_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .op_in   (op_in),
        .sat_in  (sat_en),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .s1_vld  (s1_vld),
        .s1_op   (s1_op),
        .s1_sat  (s1_sat),
        .s1_prod (s1_prod)
    );

    mac_sat_logic #(.HALF_W(HALF_W)) u_sat (
        .acc_cur (acc_q),
        .prod    (s1_prod),
        .op      (s1_op),
        .sat     (s1_sat),
        .acc_nxt (acc_nxt)
    );

    mac_acc_reg #(.HALF_W(HALF_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (s1_vld),
        .acc_nxt  (acc_nxt),
        .acc_q    (acc_q),
        .commit_q (commit_q),
        .done_q   (done)
    );

    assign acc_hi = acc_q[ACC_W-1:HALF_W];
    assign acc_lo = acc_q[HALF_W-1:0];
endmodule

// File: rtl/mac_sat_unit_chk.sv
// Module: mac_sat_unit_chk
// Protocol and result-range properties of mac_sat_unit, attached by bind.
// Assumes: the code values 01 long, 10 short, 11 clear.
module mac_sat_unit_chk #(
    parameter int HALF_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic              busy,
    input logic              done,
    input logic [HALF_W-1:0] acc_hi,
    input logic [HALF_W-1:0] acc_lo,
    input logic              s1_vld,
    input logic [1:0]        s1_op,
    input logic              s1_sat
);
    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op != 2'b00) |=> busy);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R11
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_vld |=> $stable({acc_hi, acc_lo}));

    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_op == 2'b11) |=> (acc_hi == '0 && acc_lo == '0));

    // R4 R5
    long_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_op == 2'b01 && s1_sat) |=>
        (acc_hi[HALF_W-1] ? (acc_hi[HALF_W-1:HALF_W/2] == '1)
                          : (acc_hi[HALF_W-1:HALF_W/2-1] == '0)));

    // R6 R7 R8
    short_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_op == 2'b10 && s1_sat) |=>
        ((acc_hi == HALF_W'(1)) || (acc_hi == {HALF_W{acc_lo[HALF_W-1]}})));
endmodule

bind mac_sat_unit mac_sat_unit_chk #(.HALF_W(HALF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .done      (done),
    .acc_hi    (acc_hi),
    .acc_lo    (acc_lo),
    .s1_vld    (s1_vld),
    .s1_op     (s1_op),
    .s1_sat    (s1_sat)
);

// File: tb/mac_sat_unit_bench.sv
module mac_sat_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 37;

    // {op, sat, a, b, expected hi, expected lo, requirement}
    localparam logic [138:0] VEC [NV] = '{
        {2'b01, 1'b0, 32'h00000003, 32'h00000005, 32'h00000000, 32'h0000000F, 8'd2},  // R2
        {2'b01, 1'b0, 32'hFFFFFFFE, 32'h0000000A, 32'hFFFFFFFF, 32'hFFFFFFFB, 8'd2},  // R2
        {2'b11, 1'b1, 32'hDEADBEEF, 32'h12345678, 32'h00000000, 32'h00000000, 8'd9},  // R9
        {2'b10, 1'b0, 32'hABCD0004, 32'h1234FFFD, 32'hFFFFFFFF, 32'hFFFFFFF4, 8'd3},  // R3
        {2'b10, 1'b0, 32'h00007FFF, 32'h00007FFF, 32'h00000000, 32'h3FFEFFF5, 8'd3},  // R3
        {2'b11, 1'b0, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 8'd9},  // R9
        {2'b01, 1'b0, 32'h40000000, 32'h40000000, 32'h10000000, 32'h00000000, 8'd2},  // R2
        {2'b01, 1'b1, 32'h00000001, 32'h00000001, 32'h00000000, 32'h00000001, 8'd5},  // R5
        {2'b01, 1'b1, 32'h80000000, 32'h7FFFFFFF, 32'hFFFF0000, 32'h80000001, 8'd4},  // R4
        {2'b11, 1'b0, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 8'd9},  // R9
        {2'b01, 1'b0, 32'h00010000, 32'h00010000, 32'h00000001, 32'h00000000, 8'd2},  // R2
        {2'b01, 1'b1, 32'hFFFFFFFF, 32'h00000003, 32'h00000000, 32'hFFFFFFFD, 8'd5},  // R5
        {2'b01, 1'b1, 32'h80000000, 32'h00000004, 32'hFFFFFFFE, 32'hFFFFFFFD, 8'd4},  // R4
        {2'b11, 1'b0, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 8'd9},  // R9
        {2'b01, 1'b0, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h3FFFFFFF, 32'h00000001, 8'd2},  // R2
        {2'b01, 1'b1, 32'h00000000, 32'h00000000, 32'h00007FFF, 32'h00000001, 8'd5},  // R5
        {2'b01, 1'b1, 32'h80000000, 32'h40000000, 32'hFFFF7FFF, 32'h00000001, 8'd4},  // R4
        {2'b11, 1'b0, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 8'd9},  // R9
        {2'b01, 1'b0, 32'h7FFFFFFF, 32'h00000001, 32'h00000000, 32'h7FFFFFFF, 8'd2},  // R2
        {2'b10, 1'b1, 32'h00000001, 32'h00000001, 32'h00000001, 32'h7FFFFFFF, 8'd7},  // R7
        {2'b11, 1'b0, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 8'd9},  // R9
        {2'b01, 1'b0, 32'h80000000, 32'h00000001, 32'hFFFFFFFF, 32'h80000000, 8'd2},  // R2
        {2'b10, 1'b1, 32'h0000FFFF, 32'h00000001, 32'h00000001, 32'h80000000, 8'd6},  // R6
        {2'b11, 1'b0, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 8'd9},  // R9
        {2'b01, 1'b0, 32'h80000000, 32'h00000001, 32'hFFFFFFFF, 32'h80000000, 8'd2},  // R2
        {2'b10, 1'b1, 32'hFFFF0000, 32'h00000000, 32'hFFFFFFFF, 32'h80000000, 8'd8},  // R8
        {2'b11, 1'b0, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 8'd9},  // R9
        {2'b01, 1'b0, 32'h7FFFFFFE, 32'h00000001, 32'h00000000, 32'h7FFFFFFE, 8'd2},  // R2
        {2'b10, 1'b1, 32'h00000001, 32'h00000001, 32'h00000000, 32'h7FFFFFFF, 8'd8},  // R8
        {2'b10, 1'b1, 32'h00008000, 32'h00007FFF, 32'h00000000, 32'h40007FFF, 8'd8},  // R8
        {2'b11, 1'b0, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 8'd9},  // R9
        {2'b01, 1'b0, 32'h80000000, 32'h80000000, 32'h40000000, 32'h00000000, 8'd2},  // R2
        {2'b01, 1'b0, 32'h80000000, 32'h80000000, 32'h80000000, 32'h00000000, 8'd2},  // R2
        {2'b01, 1'b0, 32'h80000000, 32'h80000000, 32'hC0000000, 32'h00000000, 8'd2},  // R2
        {2'b01, 1'b0, 32'h80000000, 32'h80000000, 32'h00000000, 32'h00000000, 8'd2},  // R2 wrap
        {2'b10, 1'b0, 32'h00008000, 32'h00008000, 32'h00000000, 32'h40000000, 8'd3},  // R3
        {2'b10, 1'b0, 32'hFFFF8000, 32'h7FFF8000, 32'h00000000, 32'h80000000, 8'd3}   // R3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic        sat_en = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        busy;
    logic        done;
    logic [31:0] acc_hi;
    logic [31:0] acc_lo;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mac_sat_unit u_mac_sat_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .sat_en(sat_en), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .busy(busy), .done(done), .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    task automatic check(input int req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Present one command for one edge, then wait for the completion pulse.
    task automatic run_cmd(input logic [1:0] op, input logic s,
                           input logic [31:0] a, input logic [31:0] b, input int req);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; sat_en = s; opnd_a = a; opnd_b = b;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
        for (int n = 0; n < 8 && !done; n++) @(negedge clk);
        check(req, "completion pulse", {63'd0, done}, 64'd1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL R10 watchdog expired: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        check(1, "reset sum", {acc_hi, acc_lo}, 64'd0);
        check(1, "reset done/busy", {62'd0, done, busy}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2..R9
        for (int i = 0; i < NV; i++) begin
            run_cmd(VEC[i][138:137], VEC[i][136], VEC[i][135:104], VEC[i][103:72],
                    int'(VEC[i][7:0]));
            check(int'(VEC[i][7:0]), $sformatf("vector %0d sum", i),
                  {acc_hi, acc_lo}, VEC[i][71:8]);
        end

        // R10: cycle-accurate timing from a cleared sum
        run_cmd(2'b11, 1'b0, 32'd0, 32'd0, 9);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b01; sat_en = 1'b0; opnd_a = 32'd2; opnd_b = 32'd3;
        @(negedge clk);  // after accepting edge
        cmd_valid = 1'b0; cmd_op = 2'b00;
        check(10, "edge1 busy/done", {62'd0, busy, done}, 64'd2);
        check(10, "edge1 sum unchanged", {acc_hi, acc_lo}, 64'd0);
        @(negedge clk);  // after commit edge
        check(10, "edge2 sum", {acc_hi, acc_lo}, 64'd6);
        check(10, "edge2 busy/done", {62'd0, busy, done}, 64'd2);
        @(negedge clk);  // after third edge
        check(10, "edge3 busy/done", {62'd0, busy, done}, 64'd1);
        @(negedge clk);
        check(10, "edge4 done low", {63'd0, done}, 64'd0);

        // R11: second command held across the busy window is dropped
        cmd_valid = 1'b1; cmd_op = 2'b01; sat_en = 1'b0; opnd_a = 32'd1; opnd_b = 32'd1;
        @(negedge clk);
        cmd_op = 2'b11;   // clear offered while busy
        @(negedge clk);
        @(negedge clk);   // done cycle: drop request before it can be taken
        cmd_valid = 1'b0; cmd_op = 2'b00;
        check(11, "done after first only", {63'd0, done}, 64'd1);
        repeat (4) begin
            @(negedge clk);
            check(11, "no extra pulse", {63'd0, done}, 64'd0);
        end
        check(11, "busy command ignored", {acc_hi, acc_lo}, 64'd7);

        // R11: code 00 is never taken
        cmd_valid = 1'b1; cmd_op = 2'b00; opnd_a = 32'd100; opnd_b = 32'd100;
        repeat (3) @(negedge clk);
        check(11, "idle code busy", {63'd0, busy}, 64'd0);
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        check(11, "idle code no done", {63'd0, done}, 64'd0);
        check(11, "idle code sum", {acc_hi, acc_lo}, 64'd7);

        // R1: reset while a command is in flight
        cmd_valid = 1'b1; cmd_op = 2'b01; opnd_a = 32'h10; opnd_b = 32'h10;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
        rst_n = 1'b0;
        @(negedge clk);
        check(1, "reset mid-op sum", {acc_hi, acc_lo}, 64'd0);
        check(1, "reset mid-op busy/done", {62'd0, busy, done}, 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(1, "no late done after reset", {63'd0, done}, 64'd0);
        check(1, "sum stays zero", {acc_hi, acc_lo}, 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule